// File: doc/BRIEF.md
# Serial-Link Interrupt Vector Prioritizer

This block sits beside a byte-level serial bus decoder. It collects the decoder's eight event strobes and chooses whether each condition goes to a DMA engine or to the CPU as an interrupt. It also forms the 8-bit interrupt vector that the CPU uses. Each strobe sets a sticky pending bit. A pending bit is cleared only by a software write-one-to-clear or, for the two DMA-capable sources, by a DMA acknowledge. Per-source mask bits decide which pending bits may raise a request.

The eight sources form four pairs, and each pair has its own vector. The low three vector bits are 000 for error/lost-arbitration, 010 for receive-full/receive-end-of-block, 100 for transmit-ready/transmit-end-of-block, and 110 for end-of-data/end-of-frame message. Software supplies bits [7:3]. Service order differs from vector order. DMA requests hold off the interrupt line. The one exception is the suspend option: when it is enabled and error and lost-arbitration are both pending, no DMA request is raised, so the interrupt path can handle the fault.

The interrupt line is a level. Once it is raised, the vector is frozen until the CPU pulses an acknowledge, and then the block arbitrates again.

Top module: `slink_irq_arb`

## Requirements
- R1: A high bit on `evt_i` sets the matching pending bit at the next edge, and the bit stays set until it is cleared. Source index: 0 error, 1 lost-arbitration, 2 receive-full, 3 receive-end-of-block, 4 transmit-ready, 5 transmit-end-of-block, 6 end-of-data, 7 end-of-frame.
- R2: Writing 1 to a status bit clears it. The status register is at address 0, with bits [5:0] = sources 7,6,4,2,1,0 read from high to low. The DMA register is at address 1, with bit 0 = source 3 and bit 1 = source 5. An event in the same cycle as the clear wins.
- R3: `irq_o` rises only if `gie_i` is high and at least one pending bit is both unmasked and routed to interrupts. Otherwise it falls, one edge after the condition ends. The mask register is at address 2, with bit n = source n.
- R4: `vec_o` = {bits [7:3] of the vector register at address 3, pair code, 0}. Pair codes are 00 for sources 0/1, 01 for 2/3, 10 for 4/5 and 11 for 6/7. A read of address 3 returns the same low bits.
- R5: Service priority from highest to lowest: pair 0/1, then pair 6/7, then pair 2/3, then pair 4/5.
- R6: While `irq_o` is high, `vec_o` does not change. `ack_i` drops `irq_o` at the next edge, and arbitration runs again on the edge after.
- R7: A pending bit left uncleared after an acknowledge raises a new request with the same vector.
- R8: Address 1 bit 5 routes receive-full to DMA and bit 6 routes transmit-ready to DMA. A routed, unmasked, pending source drives `rx_dmareq_o` or `tx_dmareq_o`. Routed sources do not raise interrupts, and any active DMA request keeps `irq_o` low.
- R9: With address 1 bit 7 set and sources 0 and 1 both pending, neither DMA request is asserted, so the interrupt proceeds.
- R10: `dma_ack_i[0]` clears the receive-full pending bit and `dma_ack_i[1]` clears the transmit-ready pending bit.
- R11: After reset every register reads 0, and `irq_o` and both DMA requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Event strobes from the decoder |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| dma_ack_i | input | 2 | DMA transfer done: bit 0 receive, bit 1 transmit |
| rx_dmareq_o | output | 1 | Receive DMA request |
| tx_dmareq_o | output | 1 | Transmit DMA request |
| irq_o | output | 1 | Interrupt request level |
| vec_o | output | 8 | Interrupt vector |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |

## Verification
The bench raises a higher-priority event while a lower vector is held. A design that re-arbitrates without an acknowledge would change `vec_o` in the middle of a request. The bench also sets and clears the same bit in one cycle, where a design that lets the clear win would lose an event. It acknowledges without clearing, to catch a design that treats the acknowledge as a clear. It enables suspend with both fault bits pending, where a design that ignores suspend would keep requesting DMA and starve the fault interrupt. Random traffic then exercises routing, masks and priority against a bench model.

// File: rtl/slink_irq_pkg.sv
package slink_irq_pkg;
  localparam int SRC_N  = 8;
  localparam int GRP_N  = SRC_N / 2;
  localparam int GRP_W  = $clog2(GRP_N);
  localparam int VEC_W  = 8;
  localparam int LOW_W  = GRP_W + 1;
  localparam int BASE_W = VEC_W - LOW_W;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam int S_ERR  = 0;
  localparam int S_TLA  = 1;
  localparam int S_RXF  = 2;
  localparam int S_RXE  = 3;
  localparam int S_TXR  = 4;
  localparam int S_TXE  = 5;
  localparam int S_EOD  = 6;
  localparam int S_EOF  = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 2'd0,
    A_DMA  = 2'd1,
    A_MASK = 2'd2,
    A_VEC  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic susp;
    logic tx_dma;
    logic rx_dma;
  } ctl_t;
endpackage

// File: rtl/slink_pend_regs.sv
module slink_pend_regs
  import slink_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic [1:0]        dma_ack_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LOW_W-1:0]  vec_low_i,
  output logic [SRC_N-1:0]  pnd_o,
  output logic [SRC_N-1:0]  mask_o,
  output logic [BASE_W-1:0] base_o,
  output ctl_t              ctl_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [SRC_N-1:0] clr;
  reg_addr_e        addr;

  assign addr = reg_addr_e'(addr_i);

  always_comb begin
    clr = '0;
    if (we_i) begin
      unique case (addr)
        A_STAT: begin
          clr[S_ERR] = wdata_i[0];
          clr[S_TLA] = wdata_i[1];
          clr[S_RXF] = wdata_i[2];
          clr[S_TXR] = wdata_i[3];
          clr[S_EOD] = wdata_i[4];
          clr[S_EOF] = wdata_i[5];
        end
        A_DMA: begin
          clr[S_RXE] = wdata_i[0];
          clr[S_TXE] = wdata_i[1];
        end
        default: ;
      endcase
    end
    clr[S_RXF] = clr[S_RXF] | dma_ack_i[0];
    clr[S_TXR] = clr[S_TXR] | dma_ack_i[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pnd_o  <= '0;
      mask_o <= '0;
      base_o <= '0;
      ctl_o  <= '0;
    end else begin
      // set beats clear
      pnd_o <= (pnd_o & ~clr) | evt_i;
      if (we_i && addr == A_MASK) mask_o <= wdata_i[SRC_N-1:0];
      if (we_i && addr == A_VEC)  base_o <= wdata_i[DATA_W-1 -: BASE_W];
      if (we_i && addr == A_DMA)  ctl_o  <= ctl_t'(wdata_i[7:5]);
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      A_STAT: rdata_o = {2'b00, pnd_o[S_EOF], pnd_o[S_EOD], pnd_o[S_TXR],
                         pnd_o[S_RXF], pnd_o[S_TLA], pnd_o[S_ERR]};
      A_DMA:  rdata_o = {ctl_o, 3'b000, pnd_o[S_TXE], pnd_o[S_RXE]};
      A_MASK: rdata_o = mask_o;
      A_VEC:  rdata_o = {base_o, vec_low_i};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/slink_grp_prio.sv
module slink_grp_prio
  import slink_irq_pkg::*;
(
  input  logic [SRC_N-1:0] pnd_i,
  input  logic [SRC_N-1:0] mask_i,
  input  ctl_t             ctl_i,
  input  logic             gie_i,
  output logic             rx_req_o,
  output logic             tx_req_o,
  output logic             req_o,
  output logic [LOW_W-1:0] low_o
);
  logic [SRC_N-1:0] act;
  logic [SRC_N-1:0] elig;
  logic [GRP_N-1:0] grp;
  logic             susp_hit;
  logic [GRP_W-1:0] best;

  assign act      = pnd_i & mask_i;
  assign susp_hit = ctl_i.susp & pnd_i[S_ERR] & pnd_i[S_TLA];
  assign rx_req_o = ctl_i.rx_dma & act[S_RXF] & ~susp_hit;
  assign tx_req_o = ctl_i.tx_dma & act[S_TXR] & ~susp_hit;

  // DMA-routed sources stay off the interrupt path
  always_comb begin
    elig        = act;
    elig[S_RXF] = act[S_RXF] & ~ctl_i.rx_dma;
    elig[S_TXR] = act[S_TXR] & ~ctl_i.tx_dma;
  end

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    assign grp[g] = |elig[2*g +: 2];
  end

  // fault, message, receive, transmit
  always_comb begin
    if (grp[0])      best = GRP_W'(0);
    else if (grp[3]) best = GRP_W'(3);
    else if (grp[1]) best = GRP_W'(1);
    else             best = GRP_W'(2);
  end

  assign low_o = {best, 1'b0};
  assign req_o = gie_i & (|grp) & ~(rx_req_o | tx_req_o);
endmodule

// File: rtl/slink_vec_hold.sv
module slink_vec_hold
  import slink_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [LOW_W-1:0]  low_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      vec_o <= '0;
    end else if (irq_o) begin
      if (ack_i || !req_i) irq_o <= 1'b0;
    end else if (req_i) begin
      irq_o <= 1'b1;
      vec_o <= {base_i, low_i};
    end
  end
endmodule

// File: rtl/slink_irq_arb.sv
module slink_irq_arb
  import slink_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic              gie_i,
  input  logic              ack_i,
  input  logic [1:0]        dma_ack_i,
  output logic              rx_dmareq_o,
  output logic              tx_dmareq_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic [SRC_N-1:0]  pnd;
  logic [SRC_N-1:0]  mask;
  logic [BASE_W-1:0] base;
  ctl_t              ctl;
  logic              req;
  logic [LOW_W-1:0]  low;
  logic              susp_en;

  assign susp_en = ctl.susp;

  slink_pend_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .dma_ack_i(dma_ack_i),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .vec_low_i(vec_o[LOW_W-1:0]),
    .pnd_o    (pnd),
    .mask_o   (mask),
    .base_o   (base),
    .ctl_o    (ctl),
    .rdata_o  (reg_rdata_o)
  );

  slink_grp_prio u_prio (
    .pnd_i   (pnd),
    .mask_i  (mask),
    .ctl_i   (ctl),
    .gie_i   (gie_i),
    .rx_req_o(rx_dmareq_o),
    .tx_req_o(tx_dmareq_o),
    .req_o   (req),
    .low_o   (low)
  );

  slink_vec_hold u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req),
    .low_i (low),
    .base_i(base),
    .ack_i (ack_i),
    .irq_o (irq_o),
    .vec_o (vec_o)
  );
endmodule

// File: rtl/slink_irq_arb_chk.sv
module slink_irq_arb_chk
  import slink_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gie_i,
  input logic             ack_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             rx_dmareq_o,
  input logic             tx_dmareq_o,
  input logic             susp_i,
  input logic [SRC_N-1:0] pnd_i
);
  AST_GIE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |=> !irq_o); // R3

  AST_VEC_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !vec_o[0]); // R4

  AST_VEC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> (!irq_o || $stable(vec_o))); // R6

  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> !irq_o); // R6

  AST_DMA_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_dmareq_o || tx_dmareq_o) |=> !irq_o); // R8

  AST_SUSP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_i && pnd_i[S_ERR] && pnd_i[S_TLA]) |-> !(rx_dmareq_o || tx_dmareq_o)); // R9
endmodule

bind slink_irq_arb slink_irq_arb_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gie_i      (gie_i),
  .ack_i      (ack_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .rx_dmareq_o(rx_dmareq_o),
  .tx_dmareq_o(tx_dmareq_o),
  .susp_i     (susp_en),
  .pnd_i      (pnd)
);

// File: tb/sim_slink_irq_arb.sv
module sim_slink_irq_arb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] evt_i = '0;
  logic       gie_i = 1'b0;
  logic       ack_i = 1'b0;
  logic [1:0] dma_ack_i = '0;
  logic       rx_dmareq_o, tx_dmareq_o, irq_o;
  logic [7:0] vec_o;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;

  int n_chk = 0;
  int n_err = 0;

  // bench model state
  logic [7:0] m_pnd, m_mask, m_vec;
  logic [4:0] m_base;
  logic [2:0] m_ctl; // {susp, tx, rx}
  logic       m_irq;

  always #5 clk_i = ~clk_i;

  slink_irq_arb u0 (.*);

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic m_hit();
    return m_ctl[2] & m_pnd[0] & m_pnd[1];
  endfunction
  function automatic logic m_rx();
    return m_ctl[0] & m_mask[2] & m_pnd[2] & ~m_hit();
  endfunction
  function automatic logic m_tx();
    return m_ctl[1] & m_mask[4] & m_pnd[4] & ~m_hit();
  endfunction

  function automatic logic [7:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return {2'b00, m_pnd[7], m_pnd[6], m_pnd[4], m_pnd[2], m_pnd[1], m_pnd[0]};
      2'd1: return {m_ctl, 3'b000, m_pnd[5], m_pnd[3]};
      2'd2: return m_mask;
      default: return {m_base, m_vec[2:0]};
    endcase
  endfunction

  // one clock: drive, advance model, check after the edge
  task automatic cyc(logic [7:0] ev, logic ak, logic [1:0] dak,
                     logic we, logic [1:0] a, logic [7:0] wd);
    logic [7:0] el, clr, n_pnd, n_mask, n_vec;
    logic [4:0] n_base;
    logic [2:0] n_ctl;
    logic [3:0] grp;
    logic [1:0] best;
    logic       req, n_irq;
    @(negedge clk_i);
    evt_i = ev; ack_i = ak; dma_ack_i = dak;
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    el = m_pnd & m_mask;
    el[2] = el[2] & ~m_ctl[0];
    el[4] = el[4] & ~m_ctl[1];
    for (int g = 0; g < 4; g++) grp[g] = el[2*g] | el[2*g+1];
    best = grp[0] ? 2'd0 : grp[3] ? 2'd3 : grp[1] ? 2'd1 : 2'd2;
    req = gie_i & (|grp) & ~(m_rx() | m_tx());
    n_irq = m_irq; n_vec = m_vec;
    if (m_irq) begin
      if (ak || !req) n_irq = 1'b0;
    end else if (req) begin
      n_irq = 1'b1; n_vec = {m_base, best, 1'b0};
    end
    clr = '0;
    if (we && a == 2'd0) begin
      clr[0] = wd[0]; clr[1] = wd[1]; clr[2] = wd[2];
      clr[4] = wd[3]; clr[6] = wd[4]; clr[7] = wd[5];
    end
    if (we && a == 2'd1) begin clr[3] = wd[0]; clr[5] = wd[1]; end
    clr[2] |= dak[0];
    clr[4] |= dak[1];
    n_pnd  = (m_pnd & ~clr) | ev;
    n_mask = (we && a == 2'd2) ? wd : m_mask;
    n_base = (we && a == 2'd3) ? wd[7:3] : m_base;
    n_ctl  = (we && a == 2'd1) ? wd[7:5] : m_ctl;
    @(posedge clk_i);
    #1;
    m_pnd = n_pnd; m_mask = n_mask; m_base = n_base; m_ctl = n_ctl;
    m_irq = n_irq; m_vec = n_vec;
    chk("R3 irq_o", 32'(irq_o), 32'(m_irq));
    chk("R6 vec_o", 32'(vec_o), 32'(m_vec));
    chk("R8 rx_dmareq_o", 32'(rx_dmareq_o), 32'(m_rx()));
    chk("R8 tx_dmareq_o", 32'(tx_dmareq_o), 32'(m_tx()));
    chk("R1 reg_rdata_o", 32'(reg_rdata_o), 32'(m_read(a)));
  endtask

  task automatic idle(int n, logic [1:0] a = 2'd0);
    for (int i = 0; i < n; i++) cyc('0, 1'b0, 2'b00, 1'b0, a, '0);
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1850));
    m_pnd = '0; m_mask = '0; m_vec = '0; m_base = '0; m_ctl = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    // R11 reset state
    chk("R11 irq_o", 32'(irq_o), 0);
    chk("R11 dma", 32'({rx_dmareq_o, tx_dmareq_o}), 0);
    rst_ni = 1'b1;
    for (int a = 0; a < 4; a++) begin
      idle(1, 2'(a));
      chk("R11 reg_rdata_o", 32'(reg_rdata_o), 0);
    end

    gie_i = 1'b1;
    cyc('0, 0, 0, 1, 2'd2, 8'hFF);
    cyc('0, 0, 0, 1, 2'd3, 8'hA8);
    cyc(8'h80, 0, 0, 0, 2'd0, '0);
    idle(2, 2'd3);
    chk("R4 vec eofm", 32'(vec_o), 32'hAE);
    chk("R4 vec readback", 32'(reg_rdata_o), 32'hAE);
    cyc(8'h01, 0, 0, 0, 2'd0, '0);
    idle(2);
    chk("R6 vec held", 32'(vec_o), 32'hAE);
    chk("R1 status", 32'(reg_rdata_o), 32'h21);
    cyc('0, 1, 0, 0, 2'd0, '0);
    idle(2);
    chk("R5 error first", 32'(vec_o), 32'hA8);
    cyc('0, 1, 0, 0, 2'd0, '0);
    idle(2);
    chk("R7 re-request", 32'(vec_o), 32'hA8);
    chk("R7 irq_o", 32'(irq_o), 1);
    cyc(8'h01, 0, 0, 1, 2'd0, 8'h01);
    chk("R2 set wins", 32'(reg_rdata_o), 32'h21);
    cyc('0, 0, 0, 1, 2'd0, 8'h01);
    chk("R2 w1c", 32'(reg_rdata_o), 32'h20);
    cyc('0, 1, 0, 0, 2'd0, '0);
    idle(2);
    chk("R5 next pair", 32'(vec_o), 32'hAE);
    cyc('0, 0, 0, 1, 2'd0, 8'h3F);
    cyc('0, 1, 0, 0, 2'd0, '0);
    idle(3);
    chk("R3 quiet", 32'(irq_o), 0);
    // DMA routing
    cyc('0, 0, 0, 1, 2'd1, 8'h20);
    cyc(8'h04, 0, 0, 0, 2'd0, '0);
    idle(2);
    chk("R8 rx dma", 32'(rx_dmareq_o), 1);
    chk("R8 no irq", 32'(irq_o), 0);
    cyc('0, 0, 2'b01, 0, 2'd0, '0);
    chk("R10 cleared", 32'(reg_rdata_o), 0);
    chk("R10 req off", 32'(rx_dmareq_o), 0);
    // suspend with both faults pending
    cyc('0, 0, 0, 1, 2'd1, 8'hA0);
    cyc(8'h04, 0, 0, 0, 2'd0, '0);
    cyc(8'h03, 0, 0, 0, 2'd0, '0);
    chk("R9 dma suspended", 32'(rx_dmareq_o), 0);
    idle(2);
    chk("R9 irq", 32'(irq_o), 1);
    chk("R9 vec", 32'(vec_o), 32'hA8);
    gie_i = 1'b0;
    idle(2);
    chk("R3 gie low", 32'(irq_o), 0);
    cyc('0, 0, 0, 1, 2'd0, 8'h3F);
    cyc('0, 0, 0, 1, 2'd1, 8'h03);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] ev;
      logic       we;
      ev = '0;
      for (int b = 0; b < 8; b++) ev[b] = ($urandom % 12) == 0;
      gie_i = ($urandom % 16) != 0;
      we = ($urandom % 4) == 0;
      cyc(ev, irq_o & (($urandom % 3) == 0),
          {tx_dmareq_o & (($urandom % 2) == 0), rx_dmareq_o & (($urandom % 2) == 0)},
          we, 2'($urandom % 4), 8'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule